// File: doc/BRIEF.md
# Set-Associative Eviction Way Picker

This block decides which way of a cache set gives up its line when a miss has to bring in new data. The cache controller reports every lookup on the access inputs: the set, whether it hit, and which way hit. It reports every line it writes into the array on the fill inputs: the set and the way. For the set currently on the access inputs it also presents the per-way valid bits. The block returns a victim way on every cycle. The controller uses that value when the lookup turns out to be a miss.

A parameter fixes one of four eviction schemes when the block is built. In random mode the way comes from a free-running shift register. In recency mode a tree of direction bits is kept per set, which gives exact LRU for two ways and pseudo-LRU for more. In round-robin mode a pointer per set is advanced by fills. The fourth mode also uses the round-robin pointer but skips the way touched last. Each set keeps only the state its scheme needs. A direct-mapped build keeps no state at all.

Top module: `set_victim_sel`

## Requirements
- R1: With `NUM_WAYS` = 1, `victimWay` is 0 on every cycle, whatever the inputs.
- R2: If any bit of `setValid` (masked to the way count) is 0, `victimWay` is the lowest index whose valid bit is 0, in every mode; the mode's own choice applies only when all ways are valid.
- R3: Recency mode with 2 ways: when all ways are valid, `victimWay` is the way of that set that was not touched last. A touch is an access with `accValid`=1 and `accHit`=1 (way `accWay`), or a fill (way `fillWay`).
- R4: Recency mode with more than 2 ways uses a tree of NUM_WAYS-1 bits per set. Node 1 is the root and node n has children 2n and 2n+1. The leaves NUM_WAYS..2*NUM_WAYS-1 are ways 0 upward. The victim walk starts at the root and goes to child 2n+bit(n). A touch sets every node on the way's path to point away from the child on that path: 1 if the path goes through the even child, 0 if it goes through the odd one.
- R5: Round-robin mode: the victim is the set's pointer. Each fill into a set moves that set's pointer to the next way, wrapping from NUM_WAYS-1 to 0. Hits do not move it.
- R6: Skip-last mode: the victim is the set's round-robin pointer (moved as in R5), unless that way is the set's last-touched way; in that case the victim is pointer+1, wrapping.
- R7: If a hit and a fill touch the same set in one cycle, the hit is applied first and the fill second. The fill way therefore becomes the last-touched way, and both paths are updated in order in the tree.
- R8: Random mode: a 16-bit register is set to 0xACE1 while `rst` is high. After that, on every clock it shifts left with new bit 0 = q[15]^q[13]^q[12]^q[10]. The victim is the register value modulo NUM_WAYS, and it does not depend on hits or fills.
- R9: `victimWay` is a combinational function of the stored state, `accSet` and `setValid`. A touch or fill changes it from the next clock edge on.
- R10: A clock edge with `rst`=1 clears all tree bits, pointers and last-touched records to 0. After reset, with all ways valid, the victim is 0 in recency and round-robin modes and 1 in skip-last mode.
- R11: An access that misses (`accValid`=1, `accHit`=0) with no fill leaves all state unchanged. An access with `accValid`=0 does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| accValid | input | 1 | A lookup is presented this cycle |
| accHit | input | 1 | The lookup hit |
| accSet | input | SET_W | Set of the lookup; also selects the set whose victim is output |
| accWay | input | WAY_W | Way that hit |
| fillValid | input | 1 | A line is written this cycle |
| fillSet | input | SET_W | Set being filled |
| fillWay | input | WAY_W | Way being filled |
| setValid | input | NUM_WAYS | Valid bits of the ways of `accSet` |
| victimWay | output | WAY_W | Way to evict from `accSet` |

## Verification
The bench builds six copies side by side, all with 4 sets. These are a direct-mapped copy, recency copies with 2 and 4 ways, and 4-way round-robin, skip-last and random copies. The 2-way copy exercises exact LRU and the 4-way copy exercises the pseudo-LRU tree. All copies see the same stimulus. Way numbers are cut to each copy's width, so the same hits and fills reach the pointer wrap, the skip of the last-touched way, same-cycle hit and fill collisions and the lowest-invalid override at every width.

// File: rtl/svs_pkg.sv
package svs_pkg;

  typedef enum logic [1:0] {
    POL_RANDOM = 2'd0,
    POL_LRU    = 2'd1,
    POL_FIFO   = 2'd2,
    POL_NMRU   = 2'd3
  } policy_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accTouch;
    logic fillTouch;
    logic ptrAdvance;
  } strobe_t;

  localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/svs_ctrl.sv
module svs_ctrl
  import svs_pkg::*;
#(
  parameter policy_e POLICY = POL_LRU
) (
  input  logic    accValid,
  input  logic    accHit,
  input  logic    fillValid,
  output strobe_t strb
);

  localparam bit TRACK_RECENCY = (POLICY == POL_LRU) || (POLICY == POL_NMRU);
  localparam bit USE_POINTER   = (POLICY == POL_FIFO) || (POLICY == POL_NMRU);

  always_comb begin
    strb.accTouch   = TRACK_RECENCY && accValid && accHit;
    strb.fillTouch  = TRACK_RECENCY && fillValid;
    strb.ptrAdvance = USE_POINTER && fillValid;
  end

endmodule

// File: rtl/svs_datapath.sv
module svs_datapath
  import svs_pkg::*;
#(
  parameter int      NUM_WAYS = 4,
  parameter int      NUM_SETS = 8,
  parameter policy_e POLICY   = POL_LRU,
  parameter int      WAY_W    = 2,
  parameter int      SET_W    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  strobe_t             strb,
  input  logic [SET_W-1:0]    accSet,
  input  logic [WAY_W-1:0]    accWay,
  input  logic [SET_W-1:0]    fillSet,
  input  logic [WAY_W-1:0]    fillWay,
  input  logic [NUM_WAYS-1:0] setValid,
  output logic [WAY_W-1:0]    victimWay
);

  generate
    if (NUM_WAYS == 1) begin : g_direct
      logic unusedDirect;
      assign unusedDirect = ^{clk, rst, strb, accSet, accWay, fillSet, fillWay, setValid};
      assign victimWay = '0;
    end else begin : g_assoc
      localparam int NODES  = NUM_WAYS - 1;
      localparam int LEVELS = $clog2(NUM_WAYS);

      logic [WAY_W-1:0] policyWay;
      logic             anyInvalid;
      logic [WAY_W-1:0] firstInvalid;

      // lowest-numbered invalid way takes precedence
      always_comb begin
        anyInvalid   = 1'b0;
        firstInvalid = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
          if (!setValid[w]) begin
            anyInvalid   = 1'b1;
            firstInvalid = WAY_W'(w);
          end
        end
      end

      assign victimWay = anyInvalid ? firstInvalid : policyWay;

      if (POLICY == POL_LRU) begin : g_tree
        logic [NODES-1:0] treeQ [NUM_SETS];

        function automatic logic [NODES-1:0] treeTouch(input logic [NODES-1:0] bits,
                                                       input logic [WAY_W-1:0] way);
          logic [NODES-1:0] res;
          int node;
          res  = bits;
          node = int'(way) + NUM_WAYS;
          for (int l = 0; l < LEVELS; l++) begin
            res[(node >> 1) - 1] = ~node[0];
            node = node >> 1;
          end
          return res;
        endfunction

        function automatic logic [WAY_W-1:0] treePick(input logic [NODES-1:0] bits);
          int node;
          node = 1;
          for (int l = 0; l < LEVELS; l++) begin
            node = 2 * node + int'(bits[node - 1]);
          end
          return WAY_W'(node - NUM_WAYS);
        endfunction

        always_ff @(posedge clk) begin
          for (int s = 0; s < NUM_SETS; s++) begin
            logic [NODES-1:0] nxt;
            nxt = treeQ[s];
            if (strb.accTouch && accSet == SET_W'(s)) nxt = treeTouch(nxt, accWay);
            if (strb.fillTouch && fillSet == SET_W'(s)) nxt = treeTouch(nxt, fillWay);
            treeQ[s] <= rst ? '0 : nxt;
          end
        end

        assign policyWay = treePick(treeQ[accSet]);

        logic unusedTree;
        assign unusedTree = strb.ptrAdvance;

      end else if (POLICY == POL_RANDOM) begin : g_rand
        logic [15:0] lfsrQ;

        always_ff @(posedge clk) begin
          if (rst) lfsrQ <= LFSR_SEED;
          else     lfsrQ <= {lfsrQ[14:0], lfsrQ[15] ^ lfsrQ[13] ^ lfsrQ[12] ^ lfsrQ[10]};
        end

        assign policyWay = WAY_W'(int'(lfsrQ) % NUM_WAYS);

        logic unusedRand;
        assign unusedRand = ^{strb, accSet, accWay, fillSet, fillWay};

      end else begin : g_ptr
        logic [WAY_W-1:0] ptrQ [NUM_SETS];

        function automatic logic [WAY_W-1:0] wrapNext(input logic [WAY_W-1:0] w);
          return (w == WAY_W'(NUM_WAYS - 1)) ? '0 : w + 1'b1;
        endfunction

        always_ff @(posedge clk) begin
          for (int s = 0; s < NUM_SETS; s++) begin
            if (rst)
              ptrQ[s] <= '0;
            else if (strb.ptrAdvance && fillSet == SET_W'(s))
              ptrQ[s] <= wrapNext(ptrQ[s]);
          end
        end

        if (POLICY == POL_NMRU) begin : g_skip
          logic [WAY_W-1:0] mruQ [NUM_SETS];

          always_ff @(posedge clk) begin
            for (int s = 0; s < NUM_SETS; s++) begin
              if (rst)
                mruQ[s] <= '0;
              else if (strb.fillTouch && fillSet == SET_W'(s))
                mruQ[s] <= fillWay;
              else if (strb.accTouch && accSet == SET_W'(s))
                mruQ[s] <= accWay;
            end
          end

          assign policyWay = (ptrQ[accSet] == mruQ[accSet]) ? wrapNext(ptrQ[accSet])
                                                            : ptrQ[accSet];
        end else begin : g_fifo
          assign policyWay = ptrQ[accSet];
          logic unusedFifo;
          assign unusedFifo = ^{strb.accTouch, strb.fillTouch, accWay, fillWay};
        end
      end
    end
  endgenerate

endmodule

// File: rtl/set_victim_sel.sv
module set_victim_sel
  import svs_pkg::*;
#(
  parameter int      NUM_WAYS = 4,
  parameter int      NUM_SETS = 8,
  parameter policy_e POLICY   = POL_LRU,
  localparam int     WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int     SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                accValid,
  input  logic                accHit,
  input  logic [SET_W-1:0]    accSet,
  input  logic [WAY_W-1:0]    accWay,
  input  logic                fillValid,
  input  logic [SET_W-1:0]    fillSet,
  input  logic [WAY_W-1:0]    fillWay,
  input  logic [NUM_WAYS-1:0] setValid,
  output logic [WAY_W-1:0]    victimWay
);

  strobe_t strb;

  svs_ctrl #(.POLICY(POLICY)) i_ctrl (
    .accValid (accValid),
    .accHit   (accHit),
    .fillValid(fillValid),
    .strb     (strb)
  );

  svs_datapath #(
    .NUM_WAYS(NUM_WAYS),
    .NUM_SETS(NUM_SETS),
    .POLICY  (POLICY),
    .WAY_W   (WAY_W),
    .SET_W   (SET_W)
  ) i_datapath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .accSet   (accSet),
    .accWay   (accWay),
    .fillSet  (fillSet),
    .fillWay  (fillWay),
    .setValid (setValid),
    .victimWay(victimWay)
  );

endmodule

// File: rtl/svs_checker.sv
module svs_checker
  import svs_pkg::*;
#(
  parameter int      NUM_WAYS = 4,
  parameter int      NUM_SETS = 8,
  parameter policy_e POLICY   = POL_LRU,
  parameter int      WAY_W    = 2,
  parameter int      SET_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                accValid,
  input logic                accHit,
  input logic [SET_W-1:0]    accSet,
  input logic [WAY_W-1:0]    accWay,
  input logic                fillValid,
  input logic [SET_W-1:0]    fillSet,
  input logic [WAY_W-1:0]    fillWay,
  input logic [NUM_WAYS-1:0] setValid,
  input logic [WAY_W-1:0]    victimWay
);

  logic afterRst;
  always_ff @(posedge clk) afterRst <= rst;

  generate
    if (NUM_WAYS == 1) begin : g_dm
      always_comb begin
        // R1
        direct_zero_chk: assert (rst || victimWay == '0);
      end
    end else begin : g_multi
      logic [NUM_WAYS-1:0] lowMask;
      assign lowMask = (NUM_WAYS'(1) << victimWay) - NUM_WAYS'(1);

      // R2
      invalid_first_chk: assert property (@(posedge clk) disable iff (rst)
        !(&setValid) |-> (!setValid[victimWay] && ((setValid & lowMask) == lowMask)));

      if (POLICY != POL_RANDOM) begin : g_rst
        // R10
        reset_state_chk: assert property (@(posedge clk) disable iff (rst)
          (afterRst && &setValid) |->
            victimWay == ((POLICY == POL_NMRU) ? WAY_W'(1) : WAY_W'(0)));
      end

      if (POLICY == POL_FIFO) begin : g_fifo
        // R5
        ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
          (!$past(fillValid) && $stable(accSet) && $stable(setValid)) |-> $stable(victimWay));
      end

      if (POLICY == POL_NMRU || (POLICY == POL_LRU && NUM_WAYS == 2)) begin : g_recent
        // R6
        skip_recent_chk: assert property (@(posedge clk) disable iff (rst)
          (accValid && accHit && !fillValid && &setValid) |=>
            (!$stable(accSet) || !(&setValid) || victimWay != $past(accWay)));
      end
    end
  endgenerate

  logic unusedChk;
  assign unusedChk = ^{fillSet, fillWay};

endmodule

bind set_victim_sel svs_checker #(
  .NUM_WAYS(NUM_WAYS),
  .NUM_SETS(NUM_SETS),
  .POLICY  (POLICY),
  .WAY_W   (WAY_W),
  .SET_W   (SET_W)
) i_svs_checker (.*);

// File: tb/test_set_victim_sel.sv
module test_set_victim_sel;
  import svs_pkg::*;

  localparam int NI   = 6;
  localparam int SETS = 4;
  // instance order: DM, LRU2, LRU4, FIFO4, NMRU4, RND4
  localparam int WAYS_OF [NI] = '{1, 2, 4, 4, 4, 4};
  localparam int POL_OF  [NI] = '{1, 1, 1, 2, 3, 0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic accValid = 1'b0, accHit = 1'b0, fillValid = 1'b0;
  logic [1:0] accSet = '0, fillSet = '0, accWay = '0, fillWay = '0;
  logic [3:0] setValid = 4'hF;

  logic [0:0] vDm, vL2;
  logic [1:0] vL4, vF, vN, vR;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  set_victim_sel #(.NUM_WAYS(1), .NUM_SETS(SETS), .POLICY(POL_LRU)) i_set_victim_sel (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accSet(accSet),
    .accWay(1'b0), .fillValid(fillValid), .fillSet(fillSet), .fillWay(1'b0),
    .setValid(setValid[0:0]), .victimWay(vDm));
  set_victim_sel #(.NUM_WAYS(2), .NUM_SETS(SETS), .POLICY(POL_LRU)) i_set_victim_sel_l2 (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accSet(accSet),
    .accWay(accWay[0]), .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay[0]),
    .setValid(setValid[1:0]), .victimWay(vL2));
  set_victim_sel #(.NUM_WAYS(4), .NUM_SETS(SETS), .POLICY(POL_LRU)) i_set_victim_sel_l4 (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accSet(accSet),
    .accWay(accWay), .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .setValid(setValid), .victimWay(vL4));
  set_victim_sel #(.NUM_WAYS(4), .NUM_SETS(SETS), .POLICY(POL_FIFO)) i_set_victim_sel_f4 (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accSet(accSet),
    .accWay(accWay), .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .setValid(setValid), .victimWay(vF));
  set_victim_sel #(.NUM_WAYS(4), .NUM_SETS(SETS), .POLICY(POL_NMRU)) i_set_victim_sel_n4 (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accSet(accSet),
    .accWay(accWay), .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .setValid(setValid), .victimWay(vN));
  set_victim_sel #(.NUM_WAYS(4), .NUM_SETS(SETS), .POLICY(POL_RANDOM)) i_set_victim_sel_r4 (
    .clk(clk), .rst(rst), .accValid(accValid), .accHit(accHit), .accSet(accSet),
    .accWay(accWay), .fillValid(fillValid), .fillSet(fillSet), .fillWay(fillWay),
    .setValid(setValid), .victimWay(vR));

  // behavioural reference state
  int treeBit [NI][SETS][4];
  int ptr     [NI][SETS];
  int lastWay [NI][SETS];
  logic [15:0] mLfsr;

  function automatic int dutVictim(int k);
    case (k)
      0: return int'(vDm);
      1: return int'(vL2);
      2: return int'(vL4);
      3: return int'(vF);
      4: return int'(vN);
      default: return int'(vR);
    endcase
  endfunction

  function automatic int expVictim(int k);
    int w = WAYS_OF[k];
    int s = int'(accSet);
    int n;
    if (w == 1) return 0;                          // R1
    for (int i = 0; i < w; i++)
      if (!setValid[i]) return i;                  // R2
    case (POL_OF[k])
      0: return int'(mLfsr) % w;                   // R8
      1: begin                                     // R3 R4
        n = 1;
        while (n < w) n = 2 * n + treeBit[k][s][n - 1];
        return n - w;
      end
      2: return ptr[k][s];                         // R5
      default: return (ptr[k][s] == lastWay[k][s]) ? (ptr[k][s] + 1) % w : ptr[k][s]; // R6
    endcase
  endfunction

  function automatic void touch(int k, int s, int way);
    int w = WAYS_OF[k];
    int n = (way % w) + w;
    lastWay[k][s] = way % w;
    while (n > 1) begin
      treeBit[k][s][n / 2 - 1] = (n % 2 == 0) ? 1 : 0;
      n = n / 2;
    end
  endfunction

  task automatic modelEdge();
    if (rst) begin
      for (int k = 0; k < NI; k++)
        for (int s = 0; s < SETS; s++) begin
          ptr[k][s] = 0;
          lastWay[k][s] = 0;
          for (int b = 0; b < 4; b++) treeBit[k][s][b] = 0;
        end
      mLfsr = 16'hACE1;
    end else begin
      mLfsr = {mLfsr[14:0], mLfsr[15] ^ mLfsr[13] ^ mLfsr[12] ^ mLfsr[10]};
      for (int k = 0; k < NI; k++) begin
        if (accValid && accHit) touch(k, int'(accSet), int'(accWay));   // R7 hit first
        if (fillValid) begin
          touch(k, int'(fillSet), int'(fillWay));
          ptr[k][int'(fillSet)] = (ptr[k][int'(fillSet)] + 1) % WAYS_OF[k];
        end
      end
    end
  endtask

  // compare all copies in the current cycle, then clock once
  task automatic cycle(string tag);
    #1;
    if (!rst) begin
      for (int k = 0; k < NI; k++) begin
        checks++;
        if (dutVictim(k) != expVictim(k)) begin
          fails++;
          $display("FAIL %s copy %0d set %0d: victim %0d expected %0d",
                   tag, k, accSet, dutVictim(k), expVictim(k));
        end
      end
    end
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic drive(logic av, logic ht, int as, int aw, logic fv, int fs, int fw, logic [3:0] vld);
    accValid = av; accHit = ht; accSet = 2'(as); accWay = 2'(aw);
    fillValid = fv; fillSet = 2'(fs); fillWay = 2'(fw); setValid = vld;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not end, got hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1'b1;
    drive(0, 0, 0, 0, 0, 0, 0, 4'hF);
    cycle("R10"); cycle("R10");
    rst = 1'b0;
    // R10: cleared state, all sets
    for (int s = 0; s < SETS; s++) begin drive(0, 0, s, 0, 0, 0, 0, 4'hF); cycle("R10"); end

    // R2: invalid ways override every mode
    drive(0, 0, 1, 0, 0, 0, 0, 4'b1101); cycle("R2");
    drive(0, 0, 1, 0, 0, 0, 0, 4'b0111); cycle("R2");
    drive(0, 0, 1, 0, 0, 0, 0, 4'b0000); cycle("R2");
    drive(0, 0, 1, 0, 0, 0, 0, 4'b1011); cycle("R2");

    // R5: fills wrap the pointer of set 0, set 2 untouched
    for (int i = 0; i < 6; i++) begin drive(0, 0, 0, 0, 1, 0, i % 4, 4'hF); cycle("R5"); end
    drive(0, 0, 2, 0, 0, 0, 0, 4'hF); cycle("R5");

    // R3 R4: hits reorder recency in set 1
    for (int i = 0; i < 8; i++) begin drive(1, 1, 1, (i * 3) % 4, 0, 0, 0, 4'hF); cycle("R4"); end
    drive(1, 1, 1, 1, 0, 0, 0, 4'hF); cycle("R3");
    drive(1, 1, 1, 0, 0, 0, 0, 4'hF); cycle("R3");

    // R6: skip-last with pointer landing on last-touched way
    drive(1, 1, 3, 0, 0, 0, 0, 4'hF); cycle("R6");
    drive(1, 1, 3, 1, 1, 3, 0, 4'hF); cycle("R6");
    drive(1, 1, 3, 1, 0, 0, 0, 4'hF); cycle("R6");
    drive(1, 1, 3, 3, 0, 0, 0, 4'hF); cycle("R6");

    // R7: hit and fill on the same set in one cycle
    drive(1, 1, 2, 3, 1, 2, 1, 4'hF); cycle("R7");
    drive(1, 1, 2, 0, 1, 2, 2, 4'hF); cycle("R7");
    drive(0, 0, 2, 0, 0, 0, 0, 4'hF); cycle("R7");

    // R11: misses and idle accesses leave state alone
    for (int i = 0; i < 4; i++) begin drive(1, 0, i, 3, 0, 0, 0, 4'hF); cycle("R11"); end
    for (int i = 0; i < 4; i++) begin drive(0, 1, i, 2, 0, 0, 0, 4'hF); cycle("R11"); end

    // R8: random copy advances every clock with no events
    for (int i = 0; i < 20; i++) begin drive(0, 0, 0, 0, 0, 0, 0, 4'hF); cycle("R8"); end

    // R1 R9: mixed traffic, victim tracked every cycle
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom), 1'($urandom), int'($urandom % 4), int'($urandom % 4),
            1'($urandom), int'($urandom % 4), int'($urandom % 4),
            ($urandom % 5 == 0) ? 4'($urandom) : 4'hF);
      cycle((i % 2 == 0) ? "R9" : "R1");
    end

    // R10: reset mid-run clears everything again
    rst = 1'b1; cycle("R10");
    rst = 1'b0;
    for (int s = 0; s < SETS; s++) begin drive(0, 0, s, 0, 0, 0, 0, 4'hF); cycle("R10"); end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule